// File: doc/BRIEF.md
# Sampling ADC Conversion Controller

This block is the digital control core of a multichannel successive-approximation converter. A conversion can be started in two ways. A hardware start line starts it on a rising edge. A software start is a start flag carried by a control-register write. Every control-register write loads a new multiplexer channel and fires an internal setup pulse. The pulse length is programmed in clock cycles. No conversion may start while that pulse is active. A software start always waits for the pulse to end, so its sampling instant is set by the pulse and not by the write. A hardware edge that arrives during the pulse is held pending and starts the conversion when the pulse ends. A sticky status bit then records that the sample was taken late.

The clock `clk` runs at twice the converter master clock. Each cycle is therefore one master half-period, and a conversion of 14.5 master clocks lasts `CONV_TICKS` = 29 cycles. During a conversion the track/hold output is in hold. The channel select can be rewritten during hold, so the input can settle while the current conversion finishes. A stub stands in for the analog converter. It captures `sample_in` at the start edge and returns that value, tagged with the channel used, when the conversion ends.

The result leaves on a valid/ready stream. `res_valid` rises when hold ends. It stays high, with data and tag unchanged, until a cycle with `res_ready` high. The stream has no back-pressure on conversions: a conversion that completes before the consumer accepts the old result overwrites it. In self-clocking output mode (`smode` = 1) the block also pulses `fsync_req` for the serial framer.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset: `th_hold`=0, `mux_sel`=0, `pulse_active`=0, `res_valid`=0, `fsync_req`=0, `late_sample`=0, `overrun`=0.
- R2: A cycle with `cfg_wr`=1 loads `cfg_chan` into `mux_sel` at that clock edge. This also holds while `th_hold`=1.
- R3: A write with `setup_len`=L makes `pulse_active` high for exactly L cycles, starting at the write edge. L=0 gives no pulse.
- R4: With `pulse_active` low and no conversion running, a 0-to-1 change of `convst` sets `th_hold` at the first clock edge that samples `convst` high.
- R5: A write with `cfg_conv`=1 and `setup_len`=L (block idle) sets `th_hold` L+1 edges after the write edge. It never sets it at the write edge.
- R6: `th_hold` stays high for exactly `CONV_TICKS` (29) consecutive cycles and then returns low.
- R7: A `convst` rising edge seen while `pulse_active`=1 is held pending. `th_hold` then rises at the edge that ends the first cycle with `pulse_active` low, and `late_sample` becomes 1 and stays 1.
- R8: A software start or a `convst` rising edge that arrives while `th_hold`=1 is dropped. It does not change the hold length, no conversion follows it, and it sets the sticky `overrun`.
- R9: `res_data` equals `sample_in` at the edge where hold began. `res_chan` equals `mux_sel` at that edge, even if the channel was rewritten during hold.
- R10: `res_valid` rises at the edge where `th_hold` falls. It stays high with stable data until a cycle with `res_ready`=1, which clears it. A newer result replaces one that was not accepted.
- R11: With `smode`=1, `fsync_req` is a one-cycle pulse in the first cycle of `res_valid`. With `smode`=0 it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control-register write strobe |
| cfg_conv | input | 1 | Software start flag of the write |
| cfg_chan | input | CH_W | Channel address of the write |
| setup_len | input | SETUP_W | Setup pulse length in cycles, loaded on each write |
| convst | input | 1 | Hardware start line, synchronous to clk |
| smode | input | 1 | 1 = self-clocking output mode |
| sample_in | input | DATA_W | Digital stand-in for the analog input |
| res_ready | input | 1 | Result consumer ready |
| th_hold | output | 1 | Track/hold mode, 1 = hold (conversion running) |
| mux_sel | output | CH_W | Multiplexer channel select |
| pulse_active | output | 1 | Internal setup pulse running |
| late_sample | output | 1 | Sticky: a hardware start was delayed by the pulse |
| overrun | output | 1 | Sticky: a start request arrived during a conversion |
| fsync_req | output | 1 | Frame-sync request to the serial framer |
| res_valid | output | 1 | Result available |
| res_data | output | DATA_W | Converted result |
| res_chan | output | CH_W | Channel the result was sampled from |

## Verification
Some rules are checked on every cycle. A conversion never begins while the setup pulse is active in the cycle before it. Every hold lasts exactly 29 cycles. A result becomes valid as hold ends and stays unchanged until it is accepted. `fsync_req` appears only with a valid result and self-clocking mode. `overrun` never clears. The channel select follows each write. Other behaviour only the bench scenarios can show. These are the exact delay from a write or a `convst` edge to hold for different pulse lengths, and the pending hardware start with its late flag. They also include the value captured when `sample_in` changes during hold, a channel rewrite in mid-conversion that leaves the result tag unchanged, a result that replaces one not yet accepted, and dropped starts that produce no extra conversion.

// File: rtl/adc_ctrl_pkg.sv
`timescale 1ns/1ps
package adc_ctrl_pkg;
  // Reason a conversion was launched; decides the late-sample status.
  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_SW      = 2'd1,
    SRC_HW      = 2'd2,
    SRC_HW_LATE = 2'd3
  } start_src_e;

  // 14.5 master clocks counted in half-periods of the master clock.
  localparam int CONV_HALF_PERIODS = 29;
endpackage

// File: rtl/setup_pulse_timer.sv
`timescale 1ns/1ps
module setup_pulse_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [W-1:0] len,
  output logic         active
);
  logic [W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (fire)            remain <= len;
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign active = (remain != '0);
endmodule

// File: rtl/start_arbiter.sv
`timescale 1ns/1ps
module start_arbiter
  import adc_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       pulse_active,
  input  logic       hw_rise,
  input  logic       sw_req,
  output logic       start,
  output start_src_e src,
  output logic       reject
);
  logic sw_pend, hw_pend;
  logic rise_used;

  always_comb begin
    start = !busy && !pulse_active && (hw_rise || sw_pend || hw_pend);
    if (!start)       src = SRC_NONE;
    else if (hw_pend) src = SRC_HW_LATE;
    else if (sw_pend) src = SRC_SW;
    else              src = SRC_HW;
    rise_used = start && (src == SRC_HW);
    reject    = (busy || start) && (sw_req || (hw_rise && !rise_used));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_pend <= 1'b0;
      hw_pend <= 1'b0;
    end else if (start) begin
      sw_pend <= 1'b0;
      hw_pend <= 1'b0;
    end else if (!busy) begin
      if (sw_req)                  sw_pend <= 1'b1;
      if (hw_rise && pulse_active) hw_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/conv_sequencer.sv
`timescale 1ns/1ps
module conv_sequencer #(
  parameter int TICKS = 29
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic hold,
  output logic done
);
  localparam int TICK_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [TICK_W-1:0] LAST = TICK_W'(TICKS - 1);

  logic [TICK_W-1:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b0;
      tick <= '0;
    end else if (start) begin
      hold <= 1'b1;
      tick <= '0;
    end else if (hold) begin
      if (tick == LAST) hold <= 1'b0;
      else              tick <= tick + 1'b1;
    end
  end

  assign done = hold && (tick == LAST);
endmodule

// File: rtl/sar_stub.sv
`timescale 1ns/1ps
module sar_stub #(
  parameter int DATA_W = 12,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] sample_in,
  input  logic [CH_W-1:0]   chan_in,
  input  logic              done,
  input  logic              res_ready,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [CH_W-1:0]   res_chan
);
  logic [DATA_W-1:0] held_val;
  logic [CH_W-1:0]   held_chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_val  <= '0;
      held_chan <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
    end else begin
      if (capture) begin
        held_val  <= sample_in;
        held_chan <= chan_in;
      end
      if (done) begin
        res_valid <= 1'b1;
        res_data  <= held_val;
        res_chan  <= held_chan;
      end else if (res_valid && res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_conv_ctrl.sv
`timescale 1ns/1ps
module adc_conv_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int N_CH       = 8,
  parameter int DATA_W     = 12,
  parameter int SETUP_W    = 8,
  parameter int CONV_TICKS = CONV_HALF_PERIODS,
  localparam int CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic               cfg_conv,
  input  logic [CH_W-1:0]    cfg_chan,
  input  logic [SETUP_W-1:0] setup_len,
  input  logic               convst,
  input  logic               smode,
  input  logic [DATA_W-1:0]  sample_in,
  input  logic               res_ready,
  output logic               th_hold,
  output logic [CH_W-1:0]    mux_sel,
  output logic               pulse_active,
  output logic               late_sample,
  output logic               overrun,
  output logic               fsync_req,
  output logic               res_valid,
  output logic [DATA_W-1:0]  res_data,
  output logic [CH_W-1:0]    res_chan
);
  logic       convst_q;
  logic       hw_rise;
  logic       start, reject, done;
  start_src_e src;

  assign hw_rise = convst && !convst_q;

  setup_pulse_timer #(.W(SETUP_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .fire(cfg_wr), .len(setup_len), .active(pulse_active)
  );

  start_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .busy(th_hold), .pulse_active(pulse_active),
    .hw_rise(hw_rise), .sw_req(cfg_wr && cfg_conv),
    .start(start), .src(src), .reject(reject)
  );

  conv_sequencer #(.TICKS(CONV_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .hold(th_hold), .done(done)
  );

  sar_stub #(.DATA_W(DATA_W), .CH_W(CH_W)) u_stub (
    .clk(clk), .rst_n(rst_n), .capture(start), .sample_in(sample_in),
    .chan_in(mux_sel), .done(done), .res_ready(res_ready),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      convst_q    <= 1'b0;
      mux_sel     <= '0;
      late_sample <= 1'b0;
      overrun     <= 1'b0;
      fsync_req   <= 1'b0;
    end else begin
      convst_q  <= convst;
      fsync_req <= done && smode;
      if (cfg_wr)                 mux_sel     <= cfg_chan;
      if (src == SRC_HW_LATE)     late_sample <= 1'b1;
      if (reject)                 overrun     <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
`timescale 1ns/1ps
module adc_conv_ctrl_chk #(
  parameter int TICKS  = 29,
  parameter int CH_W   = 3,
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [CH_W-1:0]   cfg_chan,
  input logic              smode,
  input logic              th_hold,
  input logic [CH_W-1:0]   mux_sel,
  input logic              pulse_active,
  input logic              overrun,
  input logic              fsync_req,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data
);
  logic [15:0] hold_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_run <= '0;
    else if (th_hold) hold_run <= hold_run + 1'b1;
    else              hold_run <= '0;
  end

  AST_HOLD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(th_hold) |-> hold_run == 16'(TICKS)); // R6
  AST_START_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(th_hold) |-> !$past(pulse_active)); // R7
  AST_VALID_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(th_hold) |-> res_valid); // R10
  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid); // R10
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !th_hold) |=> $stable(res_data)); // R10
  AST_FSYNC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_req |-> (res_valid && $past(smode))); // R11
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R8
  AST_MUX_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> mux_sel == $past(cfg_chan)); // R2
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(
  .TICKS(CONV_TICKS), .CH_W(CH_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_chan(cfg_chan), .smode(smode),
  .th_hold(th_hold), .mux_sel(mux_sel), .pulse_active(pulse_active),
  .overrun(overrun), .fsync_req(fsync_req), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data)
);

// File: tb/tb_adc_conv_ctrl.sv
`timescale 1ns/1ps
module tb_adc_conv_ctrl;
  localparam int CH_W = 3, DATA_W = 12, SETUP_W = 8, TICKS = 29;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_conv = 0, convst = 0, smode = 0, res_ready = 0;
  logic [CH_W-1:0] cfg_chan = '0;
  logic [SETUP_W-1:0] setup_len = '0;
  logic [DATA_W-1:0] sample_in = '0;
  logic th_hold, pulse_active, late_sample, overrun, fsync_req, res_valid;
  logic [CH_W-1:0] mux_sel, res_chan;
  logic [DATA_W-1:0] res_data;

  always #5 clk = ~clk;

  adc_conv_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_conv(cfg_conv), .cfg_chan(cfg_chan),
    .setup_len(setup_len), .convst(convst), .smode(smode), .sample_in(sample_in),
    .res_ready(res_ready), .th_hold(th_hold), .mux_sel(mux_sel),
    .pulse_active(pulse_active), .late_sample(late_sample), .overrun(overrun),
    .fsync_req(fsync_req), .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // mode 0 = software start, 1 = hardware start after pulse, 2 = hardware start during pulse
  localparam int NV = 6;
  localparam int V_MODE  [NV] = '{0, 1, 0, 1, 2, 0};
  localparam int V_SMODE [NV] = '{1, 0, 0, 1, 1, 1};
  localparam int V_SETUP [NV] = '{3, 4, 0, 1, 6, 10};
  localparam int V_CHAN  [NV] = '{2, 5, 7, 0, 4, 1};
  localparam int V_CHG   [NV] = '{-1, 1, 3, -1, 6, -1};
  localparam int V_DATA  [NV] = '{'h5A3, 'h0F0, 'hABC, 'hFFF, 'h123, 'h800};

  task automatic cfg_write(input int chan, input bit conv, input int len);
    cfg_wr = 1; cfg_conv = conv; cfg_chan = CH_W'(chan); setup_len = SETUP_W'(len);
    @(negedge clk);
    cfg_wr = 0; cfg_conv = 0;
  endtask

  task automatic wait_quiet();
    for (int k = 0; k < 300 && (pulse_active || th_hold); k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_hold_end();
    for (int k = 0; k < 300 && !th_hold; k++) @(negedge clk);
    for (int k = 0; k < 300 && th_hold; k++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit late_exp;
    late_exp = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "hold", th_hold, 0);
    check("R1", "mux_sel", mux_sel, 0);
    check("R1", "pulse", pulse_active, 0);
    check("R1", "res_valid", res_valid, 0);
    check("R1", "fsync", fsync_req, 0);
    check("R1", "flags", {late_sample, overrun}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      int edges, hlen, exp_lat;
      smode = V_SMODE[i];
      sample_in = DATA_W'(V_DATA[i]);
      if (V_MODE[i] == 0) begin
        cfg_write(V_CHAN[i], 1, V_SETUP[i]);
        edges = 1; exp_lat = V_SETUP[i] + 2;           // R5
      end else if (V_MODE[i] == 1) begin
        cfg_write(V_CHAN[i], 0, V_SETUP[i]);
        wait_quiet();
        convst = 1;
        @(negedge clk);
        edges = 1; exp_lat = 1;                          // R4
      end else begin
        cfg_write(V_CHAN[i], 0, V_SETUP[i]);
        convst = 1;
        @(negedge clk);
        edges = 1; exp_lat = V_SETUP[i] + 1;            // R7
        late_exp = 1;
      end
      while (!th_hold && edges < 400) begin @(negedge clk); edges++; end
      check(V_MODE[i] == 0 ? "R5" : (V_MODE[i] == 1 ? "R4" : "R7"), "start latency", edges, exp_lat);
      sample_in = ~DATA_W'(V_DATA[i]);
      hlen = 0;
      while (th_hold && hlen < 100) begin
        hlen++;
        if (hlen == 3 && V_CHG[i] >= 0) begin
          cfg_wr = 1; cfg_conv = 0; cfg_chan = CH_W'(V_CHG[i]); setup_len = '0;
        end
        if (hlen == 4 && V_CHG[i] >= 0) begin
          cfg_wr = 0;
          check("R2", "mux_sel during hold", mux_sel, V_CHG[i]);
        end
        @(negedge clk);
      end
      check("R6", "hold length", hlen, TICKS);
      check("R10", "res_valid at end", res_valid, 1);
      check("R9", "res_data", res_data, V_DATA[i]);
      check("R9", "res_chan", res_chan, V_CHAN[i]);
      check("R11", "fsync first cycle", fsync_req, V_SMODE[i]);
      check("R7", "late_sample", late_sample, late_exp);
      @(negedge clk);
      check("R11", "fsync one cycle", fsync_req, 0);
      check("R10", "valid held", res_valid, 1);
      res_ready = 1;
      @(negedge clk);
      res_ready = 0;
      check("R10", "valid cleared", res_valid, 0);
      convst = 0;
      wait_quiet();
    end

    // R3 pulse length
    cfg_write(0, 0, 5);
    begin
      int plen = 0;
      while (pulse_active && plen < 100) begin plen++; @(negedge clk); end
      check("R3", "pulse length 5", plen, 5);
    end
    cfg_write(2, 0, 0);
    check("R3", "no pulse for 0", pulse_active, 0);
    @(negedge clk);
    check("R3", "no pulse for 0 later", pulse_active, 0);

    // R10 replacement of an unaccepted result
    sample_in = 12'h3C3;
    cfg_write(1, 1, 0);
    wait_hold_end();
    sample_in = 12'h6A9;
    cfg_write(2, 1, 0);
    wait_hold_end();
    check("R10", "replaced data", res_data, 'h6A9);
    check("R10", "replaced chan", res_chan, 2);
    res_ready = 1; @(negedge clk); res_ready = 0;
    wait_quiet();

    // R8 starts during hold ignored
    check("R8", "overrun clear before", overrun, 0);
    cfg_write(3, 1, 0);
    for (int k = 0; k < 20 && !th_hold; k++) @(negedge clk);
    begin
      int hlen = 0, extra = 0;
      while (th_hold && hlen < 100) begin
        hlen++;
        if (hlen == 5) begin cfg_wr = 1; cfg_conv = 1; cfg_chan = 3'd3; setup_len = '0; end
        if (hlen == 6) begin cfg_wr = 0; cfg_conv = 0; end
        if (hlen == 10) convst = 1;
        @(negedge clk);
      end
      check("R8", "hold length with ignored starts", hlen, TICKS);
      check("R8", "overrun set", overrun, 1);
      for (int k = 0; k < 40; k++) begin
        if (th_hold) extra++;
        @(negedge clk);
      end
      check("R8", "no extra conversion", extra, 0);
      check("R8", "overrun sticky", overrun, 1);
    end
    convst = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule